// File: doc/BRIEF.md
# Ramped Stereo Attenuator with Soft Mute

This block sits in a stereo PCM sample path and scales each left/right sample pair by a gain taken from an 11-bit attenuation code. The gain never jumps. On every sample strobe it moves one step of a 1024-step scale toward its current target. A full-scale swing therefore takes 1024 samples, which is about 23.2 ms at 44.1 kHz. If the target changes while the gain is still moving, the gain turns toward the new target from the value it has already reached.

Two sources can pull the target to zero. The first is a soft-mute input. The second is a zero-data detector: when it is enabled and both channels have carried all-zero samples for a programmable number of consecutive strobes, it forces a mute. When the mute request goes away, the gain climbs back to the set level at the same rate.

The ramp controller is a small state machine with four states, and its state drives two status outputs:

- **GR_HOLD**: the gain equals the target and no mute is requested.
- **GR_RISE**: the gain is still below the target.
- **GR_FALL**: the gain is still above the target.
- **GR_MUTED**: the gain is at zero and a mute is requested.

The state is updated only on a sample strobe, from the gain that strobe produces:

- **to_rise**: the new gain is below the target.
- **to_fall**: the new gain is above the target.
- **to_hold**: the new gain equals the target and no mute is requested.
- **to_muted**: the new gain equals the target and a mute is requested (the target is then zero).

Any state can move to any other state.

Top module: `pcm_gain_ramp`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe: out_valid, out_left, out_right, zero_flag, ramp_busy and mute_done are all 0, and the internal gain is 0.
- R2: On the clock edge that takes a strobe, each output sample becomes (sample × gain) / 1024, rounded toward zero. The gain used is the value held before that strobe's step. out_valid is high for exactly the cycle that follows each strobe cycle. With no strobe, the output samples hold their value.
- R3: The gain changes only on a strobe cycle, and it changes by at most one step per strobe, toward the target.
- R4: The target is set by the code as follows:
  - a code from 001h to 400h sets a target equal to the code (400h is unity gain);
  - code 000h sets a target of 0 (silence);
  - any code above 400h is clamped to 400h.
- R5: When the code changes in the middle of a ramp, the gain steps toward the new target starting from the value it currently holds.
- R6: While soft_mute is high, the target is 0. After soft_mute is released, the gain ramps back to the coded level.
- R7: The zero flag rises on the strobe that completes zero_len consecutive strobes in which both samples are zero. A strobe in which either sample is non-zero clears the flag and restarts the count.
- R8: The zero flag forces the target to 0 only while zero_mute_en is high. With zero_mute_en low, the flag has no effect on the gain.
- R9: ramp_busy is high in GR_RISE and GR_FALL. mute_done is high only in GR_MUTED, and it implies a gain of 0.
- R10: Starting from a gain of 0, a target of 400h is reached after exactly 1024 strobes. ramp_busy is low after the last of those strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample pair |
| smp_left | input | SAMPLE_W | Left input sample, signed |
| smp_right | input | SAMPLE_W | Right input sample, signed |
| att_code | input | CODE_W | Attenuation code; gain = code/1024 |
| soft_mute | input | 1 | Soft-mute request |
| zero_mute_en | input | 1 | Lets the zero detector force a mute |
| zero_len | input | ZLEN_W | Number of consecutive all-zero strobes needed to raise the zero flag |
| out_valid | output | 1 | Output strobe, one cycle after smp_valid |
| out_left | output | SAMPLE_W | Scaled left sample, signed |
| out_right | output | SAMPLE_W | Scaled right sample, signed |
| zero_flag | output | 1 | Zero-data condition detected |
| ramp_busy | output | 1 | Gain is moving toward the target |
| mute_done | output | 1 | Gain has reached zero under a mute request |

## Verification
The bench builds the block with 16-bit samples, an 11-bit code and ZLEN_W = 4. A 1024-step full ramp therefore costs only about two thousand clocks, and several full ramps fit in one run. The narrow length field lets the zero-run counter reach its saturation value of 15 during a long stretch of silence, while zero_len = 3 keeps the flag's rise visible within a few strobes. A gain readback through a sample of 16384 turns the hidden gain into an exact output value of gain × 16. Together these make the step counts, the retargeting in mid-ramp and the mute entry and exit directly observable at the ports.

// File: rtl/gr_pkg.sv
package gr_pkg;

    // Ramp controller state, updated on each sample strobe
    typedef enum logic [1:0] {
        GR_HOLD  = 2'd0,
        GR_RISE  = 2'd1,
        GR_FALL  = 2'd2,
        GR_MUTED = 2'd3
    } gr_state_e;

    // Relation of a gain value to the target
    typedef enum logic [1:0] {
        REL_EQ    = 2'd0,
        REL_BELOW = 2'd1,
        REL_ABOVE = 2'd2
    } gr_rel_e;

endpackage

// File: rtl/gr_zero_watch.sv
module gr_zero_watch #(
    parameter int SAMPLE_W = 16,
    parameter int LEN_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    input  logic [LEN_W-1:0]    zero_len,
    output logic                zero_flag
);

    localparam logic [LEN_W-1:0] RUN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] run_q;
    logic [LEN_W-1:0] run_inc;
    logic             both_zero;
    logic             flag_q;

    assign both_zero = (left == '0) && (right == '0);
    assign run_inc   = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else if (strobe) begin
            if (both_zero) begin
                run_q  <= run_inc;
                flag_q <= (run_inc >= zero_len);
            end else begin
                run_q  <= '0;
                flag_q <= 1'b0;
            end
        end
    end

    assign zero_flag = flag_q;

endmodule

// File: rtl/gr_ramp_ctrl.sv
module gr_ramp_ctrl
    import gr_pkg::*;
#(
    parameter int CODE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CODE_W-1:0] code,
    input  logic              mute_req,
    output logic [CODE_W-1:0] gain,
    output gr_state_e         state
);

    localparam int                FRAC_W = CODE_W - 1;
    localparam logic [CODE_W-1:0] UNITY  = CODE_W'(1) << FRAC_W;

    gr_state_e         state_q, state_d;
    logic [CODE_W-1:0] gain_q, gain_step;
    logic [CODE_W-1:0] target;
    gr_rel_e           rel_now, rel_next;

    // Target selection: a mute wins, then the code clamped to unity
    always_comb begin
        if (mute_req)
            target = '0;
        else if (code > UNITY)
            target = UNITY;
        else
            target = code;
    end

    always_comb begin
        if (gain_q < target)      rel_now = REL_BELOW;
        else if (gain_q > target) rel_now = REL_ABOVE;
        else                      rel_now = REL_EQ;
    end

    // One step toward the target from the current gain
    always_comb begin
        unique case (rel_now)
            REL_BELOW: gain_step = gain_q + 1'b1;
            REL_ABOVE: gain_step = gain_q - 1'b1;
            default:   gain_step = gain_q;
        endcase
    end

    always_comb begin
        if (gain_step < target)      rel_next = REL_BELOW;
        else if (gain_step > target) rel_next = REL_ABOVE;
        else                         rel_next = REL_EQ;
    end

    // Next state: to_rise / to_fall / to_hold / to_muted
    always_comb begin
        state_d = state_q;
        if (strobe) begin
            unique case (rel_next)
                REL_BELOW: state_d = GR_RISE;
                REL_ABOVE: state_d = GR_FALL;
                default:   state_d = mute_req ? GR_MUTED : GR_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GR_HOLD;
        else        state_q <= state_d;
    end

    // Gain register (output of the controller)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gain_q <= '0;
        else if (strobe) gain_q <= gain_step;
    end

    assign gain  = gain_q;
    assign state = state_q;

endmodule

// File: rtl/gr_scale_lane.sv
module gr_scale_lane #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [CODE_W-1:0]   gain,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int FRAC_W = CODE_W - 1;
    localparam int PROD_W = SAMPLE_W + CODE_W + 1;

    localparam logic signed [PROD_W-1:0] BIAS =
        {{(PROD_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};

    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   biased;
    logic signed [PROD_W-1:0]   shifted;
    logic signed [SAMPLE_W-1:0] result_q;

    // The bias added to negative products makes the shift round toward zero
    assign prod    = PROD_W'(sample) * $signed({1'b0, gain});
    assign biased  = prod[PROD_W-1] ? prod + BIAS : prod;
    assign shifted = biased >>> FRAC_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= '0;
        else if (strobe) result_q <= shifted[SAMPLE_W-1:0];
    end

    assign result = result_q;

endmodule

// File: rtl/pcm_gain_ramp.sv
module pcm_gain_ramp
    import gr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 11,
    parameter int ZLEN_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_left,
    input  logic signed [SAMPLE_W-1:0] smp_right,
    input  logic        [CODE_W-1:0]   att_code,
    input  logic                       soft_mute,
    input  logic                       zero_mute_en,
    input  logic        [ZLEN_W-1:0]   zero_len,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic                       zero_flag,
    output logic                       ramp_busy,
    output logic                       mute_done
);

    localparam int NCH = 2;

    logic              zflag_w;
    logic              mute_req;
    logic [CODE_W-1:0] gain_w;
    gr_state_e         state_w;
    logic              valid_q;

    logic [NCH-1:0][SAMPLE_W-1:0] lane_in;
    logic [NCH-1:0][SAMPLE_W-1:0] lane_out;

    assign lane_in[0] = smp_left;
    assign lane_in[1] = smp_right;

    gr_zero_watch #(
        .SAMPLE_W (SAMPLE_W),
        .LEN_W    (ZLEN_W)
    ) zero_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (smp_valid),
        .left      (smp_left),
        .right     (smp_right),
        .zero_len  (zero_len),
        .zero_flag (zflag_w)
    );

    assign mute_req = soft_mute | (zero_mute_en & zflag_w);

    gr_ramp_ctrl #(
        .CODE_W (CODE_W)
    ) ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (smp_valid),
        .code     (att_code),
        .mute_req (mute_req),
        .gain     (gain_w),
        .state    (state_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic signed [SAMPLE_W-1:0] res_w;
        gr_scale_lane #(
            .SAMPLE_W (SAMPLE_W),
            .CODE_W   (CODE_W)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (smp_valid),
            .sample ($signed(lane_in[c])),
            .gain   (gain_w),
            .result (res_w)
        );
        assign lane_out[c] = res_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= smp_valid;
    end

    assign out_valid = valid_q;
    assign out_left  = $signed(lane_out[0]);
    assign out_right = $signed(lane_out[1]);
    assign zero_flag = zflag_w;
    assign ramp_busy = (state_w == GR_RISE) || (state_w == GR_FALL);
    assign mute_done = (state_w == GR_MUTED);

endmodule

// File: rtl/gr_checks.sv
module gr_checks #(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 11
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic signed [SAMPLE_W-1:0] smp_left,
    input logic signed [SAMPLE_W-1:0] smp_right,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_left,
    input logic signed [SAMPLE_W-1:0] out_right,
    input logic                       zero_flag,
    input logic                       mute_done,
    input logic        [CODE_W-1:0]   gain_w
);

    localparam logic [CODE_W-1:0] UNITY = CODE_W'(1) << (CODE_W - 1);

    assert_gain_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(gain_w));

    assert_gain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (gain_w == $past(gain_w)) ||
                      (gain_w == $past(gain_w) + 1'b1) ||
                      (gain_w + 1'b1 == $past(gain_w)));

    assert_gain_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gain_w <= UNITY);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);

    assert_silent_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && gain_w == '0) |=> (out_left == '0) && (out_right == '0));

    assert_nonzero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_left != '0 || smp_right != '0)) |=> !zero_flag);

    assert_muted_is_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mute_done |-> (gain_w == '0));

endmodule

bind pcm_gain_ramp gr_checks #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .zero_flag (zero_flag),
    .mute_done (mute_done),
    .gain_w    (gain_w)
);

// File: tb/pcm_gain_ramp_tb_top.sv
module pcm_gain_ramp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW  = 16;
    localparam int CW  = 11;
    localparam int ZW  = 4;
    localparam int ZMAX = (1 << ZW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] smp_left = '0;
    logic signed [SW-1:0] smp_right = '0;
    logic        [CW-1:0] att_code = '0;
    logic                 soft_mute = 1'b0;
    logic                 zero_mute_en = 1'b0;
    logic        [ZW-1:0] zero_len = '0;
    logic                 out_valid;
    logic signed [SW-1:0] out_left;
    logic signed [SW-1:0] out_right;
    logic                 zero_flag;
    logic                 ramp_busy;
    logic                 mute_done;

    pcm_gain_ramp #(.SAMPLE_W(SW), .CODE_W(CW), .ZLEN_W(ZW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .att_code(att_code),
        .soft_mute(soft_mute), .zero_mute_en(zero_mute_en), .zero_len(zero_len),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .zero_flag(zero_flag), .ramp_busy(ramp_busy), .mute_done(mute_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Behavioural reference: gain as an integer, mode as a small integer
    int m_gain = 0, m_run = 0, m_mode = 0;   // mode 0 hold, 1 rise, 2 fall, 3 muted
    int m_l = 0, m_r = 0;
    bit m_flag = 0, m_v = 0;

    always @(posedge clk) begin
        int tgt, gnew, il, ir;
        bit mreq;
        if (!rst_n) begin
            m_gain = 0; m_run = 0; m_mode = 0; m_l = 0; m_r = 0; m_flag = 0; m_v = 0;
        end else begin
            m_v = smp_valid;
            if (smp_valid) begin
                mreq = soft_mute || (zero_mute_en && m_flag);
                tgt  = mreq ? 0 : ((int'(att_code) > 1024) ? 1024 : int'(att_code));
                il = int'(smp_left);
                ir = int'(smp_right);
                m_l = (il * m_gain) / 1024;
                m_r = (ir * m_gain) / 1024;
                gnew = m_gain;
                if (tgt > m_gain) gnew = m_gain + 1;
                if (tgt < m_gain) gnew = m_gain - 1;
                m_gain = gnew;
                if (gnew < tgt)      m_mode = 1;
                else if (gnew > tgt) m_mode = 2;
                else                 m_mode = mreq ? 3 : 0;
                if (il == 0 && ir == 0) begin
                    if (m_run < ZMAX) m_run++;
                    m_flag = (m_run >= int'(zero_len));
                end else begin
                    m_run = 0;
                    m_flag = 0;
                end
            end
        end
    end

    // Per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2", "out_valid", int'(out_valid), int'(m_v));
            check("R2", "out_left",  int'(out_left),  m_l);
            check("R2", "out_right", int'(out_right), m_r);
            check("R7", "zero_flag", int'(zero_flag), int'(m_flag));
            check("R9", "ramp_busy", int'(ramp_busy), int'(m_mode == 1 || m_mode == 2));
            check("R9", "mute_done", int'(mute_done), int'(m_mode == 3));
        end
    end

    task automatic put(int l, int r);
        @(negedge clk); #1;
        smp_valid = 1'b1;
        smp_left  = SW'(l);
        smp_right = SW'(r);
        @(negedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic run(int n, int l, int r);
        for (int i = 0; i < n; i++) put(l, r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        zero_len = ZW'(3);
        repeat (3) @(negedge clk);
        // R1: state while in reset and right after release
        check("R1", "valid in reset", int'(out_valid), 0);
        check("R1", "left in reset", int'(out_left), 0);
        @(negedge clk); #1; rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", "right after reset", int'(out_right), 0);
        check("R1", "zero_flag after reset", int'(zero_flag), 0);
        check("R1", "ramp_busy after reset", int'(ramp_busy), 0);
        check("R1", "mute_done after reset", int'(mute_done), 0);

        // R10: full ramp up from 0 to 400h
        att_code = 11'h400;
        put(1000, 1000);
        check("R1", "first out at gain 0", int'(out_left), 0);
        check("R10", "busy after first step", int'(ramp_busy), 1);
        run(1023, 1000, 1000);
        check("R10", "busy after 1024 steps", int'(ramp_busy), 0);
        put(16384, 16384);
        check("R10", "gain after 1024 steps", int'(out_left), 16384);

        // R2/R4: unity gain is exact
        put(-12345, 321);
        check("R2", "400h left", int'(out_left), -12345);
        check("R2", "400h right", int'(out_right), 321);

        // R4: 200h halves, rounded toward zero
        att_code = 11'h200;
        run(512, 7, 7);
        put(-12345, 12345);
        check("R4", "200h left", int'(out_left), -6172);
        check("R4", "200h right", int'(out_right), 6172);

        // R4: 001h, smallest non-zero gain
        att_code = 11'h001;
        run(511, 7, 7);
        put(-32768, 32767);
        check("R4", "001h left", int'(out_left), -32);
        check("R4", "001h right", int'(out_right), 31);

        // R5: retarget mid-ramp continues from the reached gain
        att_code = 11'h400;
        run(100, 9, 9);
        att_code = 11'h050;
        put(16384, 16384);
        check("R5", "gain at retarget", int'(out_left), 101 * 16);
        check("R5", "falling after retarget", int'(ramp_busy), 1);
        run(20, 9, 9);
        put(16384, 16384);
        check("R5", "gain at new target", int'(out_left), 80 * 16);

        // R4: code 000h silences
        att_code = 11'h000;
        run(80, 9, 9);
        put(16384, 16384);
        check("R4", "000h output", int'(out_left), 0);
        check("R4", "000h is not a mute", int'(mute_done), 0);

        // R4: codes above 400h clamp
        att_code = 11'h7FF;
        run(1024, 9, 9);
        put(16384, 16384);
        check("R4", "clamped gain", int'(out_left), 16384);
        check("R4", "clamped holds", int'(ramp_busy), 0);

        // R6: soft mute down and back
        soft_mute = 1'b1;
        run(1024, 9, 9);
        check("R6", "muted after ramp", int'(mute_done), 1);
        put(16384, 16384);
        check("R6", "muted output", int'(out_left), 0);
        soft_mute = 1'b0;
        run(1024, 9, 9);
        put(16384, 16384);
        check("R6", "released gain", int'(out_left), 16384);

        // R7/R8: zero detection, disabled mute first
        att_code = 11'h400;
        put(0, 5);
        check("R7", "one channel nonzero", int'(zero_flag), 0);
        run(2, 0, 0);
        check("R7", "short zero run", int'(zero_flag), 0);
        put(0, 0);
        check("R7", "zero run complete", int'(zero_flag), 1);
        run(20, 0, 0);
        check("R8", "disabled: no mute", int'(mute_done), 0);
        put(16384, 0);
        check("R8", "disabled: gain kept", int'(out_left), 16384);
        check("R7", "nonzero releases", int'(zero_flag), 0);

        zero_mute_en = 1'b1;
        run(3, 0, 0);
        check("R7", "flag again", int'(zero_flag), 1);
        run(1024, 0, 0);
        check("R8", "zero mute reached", int'(mute_done), 1);
        put(16384, 16384);
        check("R8", "muted by zeros", int'(out_left), 0);
        put(16384, 16384);
        check("R8", "release starts at 0", int'(out_left), 0);
        put(16384, 16384);
        check("R8", "ramp back up", int'(out_left), 16);

        // R3: no strobes, gain unchanged
        repeat (25) @(negedge clk);
        #1;
        put(16384, 16384);
        check("R3", "gain held while idle", int'(out_left), 32);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule